// File: doc/BRIEF.md
# Serial EEPROM Boot Probe Controller

This block runs once after reset and decides how the device identifies itself. It acts as master on a two-wire serial bus and reads a serial EEPROM from its power-up current address, which is zero. The first byte it reads is a signature, and the signature picks one of three outcomes.

The first outcome keeps the built-in vendor, product and release identifiers. The second replaces those three identifiers with values stored in the EEPROM. The third copies a code image from the EEPROM into on-chip RAM through a simple write port.

The two bus lines are open-drain. The block only ever pulls a line low or lets it go, and external pull-ups raise it. The block does not use the bus again after it finishes. When it is done it issues a single done pulse, and a 2-bit code tells the rest of the chip which outcome was taken.

Top module: `boot_probe_ctrl`

## Requirements
- R1: During reset and immediately after it, both line-pull outputs are 0 (lines released), `done` is 0 and `mode` is 2'b00. The identifiers hold the built-in values: vendor 16'h04B4, product 16'h8613, release {4'hA, REV}, which is 16'hA001 at the default REV of 12'h001.
- R2: The block issues one START condition and then sends the control byte {DEV_ADDR, 1'b1} (read), most significant bit first. If the acknowledge slot after that byte reads high (no device), the block issues STOP, keeps the built-in identifiers and ends with mode 2'b00.
- R3: If the first data byte is neither 8'hC0 nor 8'hC2, the master answers that byte with NACK, reads nothing more, issues STOP and ends with mode 2'b00 and the built-in identifiers.
- R4: After a first byte of 8'hC0, the block reads exactly six more bytes (seven in total). These are vendor, product and release, each with the low byte first, and they replace the identifier outputs. The block ends with mode 2'b01.
- R5: After a first byte of 8'hC2, the block reads a 16-bit length and then a 16-bit load address, both low byte first. It then reads exactly length data bytes and writes them with one single-cycle `ram_we` pulse each, to consecutive addresses starting at the load address. It ends with mode 2'b10.
- R6: An image byte whose target address is RAM_DEPTH or higher is still read from the bus but is not written.
- R7: An image with length zero causes no RAM write. The address-high byte is the last byte read, and the mode is 2'b10.
- R8: `done` is high for exactly one cycle per boot. `mode` changes only in that cycle. After `done`, both lines stay released, no RAM write occurs and the identifiers stay constant.
- R9: The master acknowledges every byte it reads except the last one. The SCL period is 4*DIV_STD clock cycles when `fast_sel` is 0 and 4*DIV_FAST clock cycles when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; a boot starts when it is released |
| fast_sel | input | 1 | 1 selects the fast bus rate, 0 selects the standard rate |
| sda_in | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | $clog2(RAM_DEPTH) | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| vid | output | 16 | Vendor identifier |
| pid | output | 16 | Product identifier |
| did | output | 16 | Release identifier |
| done | output | 1 | One-cycle pulse when the boot decision is complete |
| mode | output | 2 | 00 built-in identifiers, 01 identifiers loaded, 10 image loaded |

## Verification
The assertions assume the following about the inputs:
- `fast_sel` stays steady during a boot.
- The EEPROM changes the data line only while the clock line is low.
- The EEPROM never stretches the clock.
- Each boot begins from a reset pulse.

The bench's EEPROM model keeps to these rules. It changes its data drive only on falling clock edges and acknowledges only the expected read control byte. The bench holds `fast_sel` constant for each run and applies a fresh reset before every boot, with random headers, identifiers, lengths and load addresses.

// File: rtl/boot_probe_ctrl.sv
module boot_probe_ctrl #(
  parameter int DIV_STD = 120,
  parameter int DIV_FAST = 30,
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int RAM_DEPTH = 1024,
  parameter logic [11:0] REV = 12'h001,
  localparam int AW = $clog2(RAM_DEPTH),
  localparam int DW = $clog2(DIV_STD > DIV_FAST ? DIV_STD : DIV_FAST) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fast_sel,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic [15:0]   vid,
  output logic [15:0]   pid,
  output logic [15:0]   did,
  output logic          done,
  output logic [1:0]    mode
);
  localparam logic [15:0] VID0 = 16'h04B4;
  localparam logic [15:0] PID0 = 16'h8613;
  localparam logic [15:0] DID0 = {4'hA, REV};

  typedef enum logic [2:0] {ST_START, ST_ADDR, ST_READ, ST_STOP, ST_END} st_t;
  st_t st;

  logic [DW-1:0] div_q;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [7:0]    sh;
  logic [16:0]   idx, wa;
  logic [15:0]   len;
  logic [1:0]    kind;
  logic          nack, tick, last;

  assign tick = div_q >= DW'(fast_sel ? DIV_FAST - 1 : DIV_STD - 1);

  assign last = (idx == 17'd0) ? !(sh == 8'hC0 || sh == 8'hC2)
              : (kind == 2'd1) ? (idx == 17'd6)
              : (idx < 17'd4)  ? 1'b0
              : ((idx - 17'd4) == {1'b0, len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_START; div_q <= '0; ph <= '0; bitn <= '0; sh <= '0;
      idx <= '0; wa <= '0; len <= '0; kind <= '0; nack <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
      ram_we <= 1'b0; ram_addr <= '0; ram_wdata <= '0;
      vid <= VID0; pid <= PID0; did <= DID0;
      done <= 1'b0; mode <= 2'b00;
    end else begin
      ram_we <= 1'b0;
      done   <= 1'b0;
      div_q  <= tick ? '0 : div_q + DW'(1);
      if (tick && st != ST_END) begin
        ph <= ph + 2'd1;
        case (st)
          ST_START: case (ph)
            2'd1: sda_oe <= 1'b1;
            2'd2: scl_oe <= 1'b1;
            2'd3: begin st <= ST_ADDR; sh <= {DEV_ADDR, 1'b1}; bitn <= '0; end
            default: ;
          endcase
          ST_ADDR, ST_READ: case (ph)
            2'd0: begin
              scl_oe <= 1'b1;
              if (bitn == 4'd8) sda_oe <= (st == ST_READ) && !last;
              else              sda_oe <= (st == ST_ADDR) && !sh[7];
            end
            2'd1: scl_oe <= 1'b0;
            2'd2: if (bitn == 4'd8) nack <= sda_in;
                  else              sh <= {sh[6:0], sda_in};
            default: begin
              scl_oe <= 1'b1;
              if (bitn != 4'd8) bitn <= bitn + 4'd1;
              else begin
                bitn <= '0;
                if (st == ST_ADDR) st <= nack ? ST_STOP : ST_READ;
                else begin
                  idx <= idx + 17'd1;
                  if (last) st <= ST_STOP;
                  if (idx == 17'd0)
                    kind <= (sh == 8'hC0) ? 2'd1 : (sh == 8'hC2) ? 2'd2 : 2'd0;
                  else if (kind == 2'd1) begin
                    case (idx[2:0])
                      3'd1: vid[7:0]  <= sh;
                      3'd2: vid[15:8] <= sh;
                      3'd3: pid[7:0]  <= sh;
                      3'd4: pid[15:8] <= sh;
                      3'd5: did[7:0]  <= sh;
                      default: did[15:8] <= sh;
                    endcase
                  end else begin
                    case (idx)
                      17'd1: len[7:0]  <= sh;
                      17'd2: len[15:8] <= sh;
                      17'd3: wa <= {9'd0, sh};
                      17'd4: wa[16:8] <= {1'b0, sh};
                      default: begin
                        if (wa < 17'(RAM_DEPTH)) begin
                          ram_we    <= 1'b1;
                          ram_addr  <= wa[AW-1:0];
                          ram_wdata <= sh;
                        end
                        wa <= wa + 17'd1;
                      end
                    endcase
                  end
                end
              end
            end
          endcase
          ST_STOP: case (ph)
            2'd0: begin scl_oe <= 1'b1; sda_oe <= 1'b1; end
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: begin st <= ST_END; done <= 1'b1; mode <= kind; end
          endcase
          default: ;
        endcase
      end
    end
  end
endmodule

module boot_probe_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        ram_we,
  input logic        done,
  input logic [1:0]  mode,
  input logic [15:0] vid,
  input logic [15:0] pid,
  input logic [15:0] did
);
  logic fin;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fin <= 1'b0;
    else if (done) fin <= 1'b1;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_mode_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> done);
  assert_quiet_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (!ram_we && !scl_oe && !sda_oe && !done));
  assert_ids_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ($stable(vid) && $stable(pid) && $stable(did)));
  assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);
  assert_mode_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mode != 2'b11);
endmodule

bind boot_probe_ctrl boot_probe_ctrl_chk u_chk (.*);

// File: tb/boot_probe_ctrl_tb.sv
module boot_probe_ctrl_tb;
  localparam int DS = 8, DF = 2, DEPTH = 256;

  logic clk = 1'b0, rst_n = 1'b0, fast_sel = 1'b0, slv_low = 1'b0;
  logic scl_oe, sda_oe, ram_we, done;
  logic [7:0] ram_addr, ram_wdata;
  logic [15:0] vid, pid, did;
  logic [1:0] mode;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || slv_low);

  boot_probe_ctrl #(.DIV_STD(DS), .DIV_FAST(DF), .RAM_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .sda_in(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .vid(vid), .pid(pid), .did(did), .done(done), .mode(mode));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, prev_fall = 0, last_fall = 0, nwr = 0, ndone = 0;
  logic [7:0] bram [0:DEPTH-1];
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (ram_we) begin bram[ram_addr] = ram_wdata; nwr++; end
    if (done) ndone++;
  end
  always @(negedge scl) begin prev_fall = last_fall; last_fall = cyc; end

  // EEPROM model: 0 idle, 1 control byte, 2 sending data
  logic eeprom_on = 1'b0, acked = 1'b0, mack = 1'b0;
  logic [7:0] mem [0:63];
  logic [7:0] rx = 8'h00;
  int ph_m = 0, k = 0, ptr = 0, nread = 0;

  always @(negedge sda) if (scl) begin ph_m = 1; k = 0; rx = 8'h00; slv_low = 1'b0; end
  always @(posedge sda) if (scl) begin ph_m = 0; slv_low = 1'b0; end
  always @(posedge scl) begin
    if (ph_m == 1 && k < 8) begin rx = {rx[6:0], sda}; k++; end
    else if (ph_m == 2 && k == 8) mack = !sda;
  end
  always @(negedge scl) begin
    if (ph_m == 1) begin
      if (k == 8) begin acked = eeprom_on && rx == 8'hA1; slv_low = acked; k = 9; end
      else if (k == 9) begin
        if (acked) begin ph_m = 2; k = 0; nread++; slv_low = !mem[ptr][7]; end
        else begin ph_m = 0; slv_low = 1'b0; end
      end
    end else if (ph_m == 2) begin
      if (k < 7) begin k++; slv_low = !mem[ptr][7-k]; end
      else if (k == 7) begin k = 8; slv_low = 1'b0; end
      else if (mack) begin ptr++; k = 0; nread++; slv_low = !mem[ptr][7]; end
      else begin ph_m = 0; slv_low = 1'b0; end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int in_range(input int addr, input int len);
    int n = 0;
    for (int i = 0; i < len; i++) if (addr + i < DEPTH) n++;
    return n;
  endfunction

  task automatic boot(input bit pres, input bit fast);
    @(negedge clk);
    rst_n = 1'b0; eeprom_on = pres; fast_sel = fast;
    ptr = 0; nread = 0; nwr = 0; ndone = 0; acked = 1'b0;
    for (int i = 0; i < DEPTH; i++) bram[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (ndone == 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R8", "done count", ndone, 1);
    chk("R8", "lines released", {scl_oe, sda_oe}, 0);
    chk("R9", "scl period", last_fall - prev_fall, 4 * (fast ? DF : DS));
  endtask

  task automatic check_defaults(input string req);
    chk(req, "mode", mode, 0);
    chk(req, "vid", vid, 16'h04B4);
    chk(req, "pid", pid, 16'h8613);
    chk(req, "did", did, 16'hA001);
    chk(req, "writes", nwr, 0);
  endtask

  task automatic image(input int addr, input int len, input bit fast);
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    mem[0] = 8'hC2; mem[1] = 8'(len); mem[2] = 8'(len >> 8);
    mem[3] = 8'(addr); mem[4] = 8'(addr >> 8);
    boot(1'b1, fast);
    chk("R5", "mode", mode, 2);
    chk("R9", "bytes read", nread, 5 + len);
    chk("R6", "write count", nwr, in_range(addr, len));
    for (int i = 0; i < len; i++)
      if (addr + i < DEPTH) chk("R5", "ram byte", bram[addr + i], mem[5 + i]);
  endtask

  initial begin
    #(190000 * 8);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    chk("R1", "lines in reset", {scl_oe, sda_oe}, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "mode in reset", mode, 0);
    chk("R1", "vid in reset", vid, 16'h04B4);
    chk("R1", "pid in reset", pid, 16'h8613);
    chk("R1", "did in reset", did, 16'hA001);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "lines after reset", {scl_oe, sda_oe}, 0);

    boot(1'b0, 1'b0);
    check_defaults("R2");
    chk("R2", "no bytes without device", nread, 0);

    mem[0] = 8'hFF;
    boot(1'b1, 1'b1);
    chk("R2", "control byte acked", acked, 1);
    check_defaults("R3");
    chk("R3", "header only read", nread, 1);

    mem[0] = 8'hC1;
    boot(1'b1, 1'b0);
    check_defaults("R3");
    chk("R3", "near-signature read", nread, 1);

    for (int n = 0; n < 2; n++) begin
      logic [7:0] h;
      do h = 8'($urandom); while (h == 8'hC0 || h == 8'hC2);
      mem[0] = h;
      boot(1'b1, n[0]);
      check_defaults("R3");
    end

    for (int n = 0; n < 3; n++) begin
      logic [15:0] ev, ep, ed;
      ev = 16'($urandom); ep = 16'($urandom); ed = 16'($urandom);
      mem[0] = 8'hC0; mem[1] = ev[7:0]; mem[2] = ev[15:8];
      mem[3] = ep[7:0]; mem[4] = ep[15:8]; mem[5] = ed[7:0]; mem[6] = ed[15:8];
      mem[7] = 8'h5A;
      boot(1'b1, n[0]);
      chk("R4", "mode", mode, 1);
      chk("R4", "vid", vid, ev);
      chk("R4", "pid", pid, ep);
      chk("R4", "did", did, ed);
      chk("R4", "bytes read", nread, 7);
      chk("R4", "writes", nwr, 0);
    end

    for (int n = 0; n < 3; n++) begin
      int len, addr;
      len = $urandom_range(1, 30);
      addr = $urandom_range(0, DEPTH - len);
      image(addr, len, n[0]);
    end

    image(DEPTH - 3, 6, 1'b1);   // R6 partly outside
    image(16'h1234, 4, 1'b1);    // R6 fully outside
    image(17, 0, 1'b0);          // R7 empty image
    chk("R7", "no write for empty image", nwr, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule